// File: doc/BRIEF.md
# Dual Multiply-Add Summation Slice

This slice takes four operand pairs and forms four products. The first two products are combined by an add/subtract stage and the last two by a second one. Each stage has its own operation control. The two partial results are then added into one final sum. Result widths grow with each level: a product of an `A_W`-bit and a `B_W`-bit operand is `A_W+B_W` bits, each partial result is one bit wider, and the final sum is two bits wider.

There are three register stages: input, pipeline and output. A parameter keeps or removes each stage. Each kept stage picks one line from a shared bank of four clock enables and one line from a shared bank of four synchronous clears. The add/sub controls and the signedness control travel through the input and pipeline stages beside the data, so they are always applied to the operands they were presented with. The A and B input registers can also be run as shift chains. Each chain has a shift-in port and a shift-out port, so several slices can pass operands along without routing them back through the fabric.

Top module: `mas4_slice`

## Requirements
- R1: While `rst_n` is low, `sum_out`, `sa_out` and `sb_out` are all zero.
- R2: The partial result of lanes 0 and 1 is P0+P1 when `add_sel0` is 1 and P0−P1 when it is 0, where Pi = lane i A operand × lane i B operand. Lanes 2 and 3 work the same way under `add_sel1`.
- R3: `sum_out` equals the exact integer (partial0 + partial1) modulo 2^(A_W+B_W+2). Operands are two's complement when `ops_signed` is 1 and unsigned when it is 0. Lane i of `a_in` occupies bits [i*A_W +: A_W], and the same layout with B_W applies to `b_in`.
- R4: In unsigned mode, a subtraction partial result is a signed difference and is sign-extended into the final sum. An addition partial result is zero-extended. With all-add unsigned operation, the sum never wraps below either partial result.
- R5: With all three stages kept, the result of inputs presented before clock edge k appears on `sum_out` after edge k+2. Operation and signedness controls stay aligned with their data.
- R6: A kept stage whose selected `ce_bank` line is low holds its contents across the edge.
- R7: A kept stage whose selected `clr_bank` line is high is cleared at the next edge, whatever its enable. The other stages are not affected.
- R8: `ce_bank` and `clr_bank` lines that no stage selects have no effect on any output.
- R9: With `shift_a` high, A register 0 loads `sa_in` and A register i loads A register i−1. `sa_out` always shows A register 3. The B chain works the same way under `shift_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_bank | input | 4 | Shared clock-enable lines |
| clr_bank | input | 4 | Shared synchronous clear lines, active high |
| a_in | input | 4*A_W | Four A operands, lane 0 in the low bits |
| b_in | input | 4*B_W | Four B operands, lane 0 in the low bits |
| add_sel0 | input | 1 | Lanes 0/1 operation: 1 add, 0 subtract |
| add_sel1 | input | 1 | Lanes 2/3 operation: 1 add, 0 subtract |
| ops_signed | input | 1 | 1 two's complement, 0 unsigned |
| shift_a | input | 1 | A registers load from the chain |
| shift_b | input | 1 | B registers load from the chain |
| sa_in | input | A_W | A chain shift-in |
| sb_in | input | B_W | B chain shift-in |
| sa_out | output | A_W | A chain shift-out (A register 3) |
| sb_out | output | B_W | B chain shift-out (B register 3) |
| sum_out | output | A_W+B_W+2 | Final sum |

## Verification
The bench uses the default build. The operands are 8 and 6 bits wide, so a lane swap or a mixed-up width shows up. All three stages are kept. The stages select enable lines 0, 1 and 2 and clear lines 1, 2 and 3. That leaves enable line 3 and clear line 0 unused, and the bench toggles both to show they have no effect. Because every stage uses a different line, each stage can be stalled or cleared on its own and the effect lands in a known output slot. A 16-bit sum is small enough to check every extreme signed and unsigned combination against a bench model built on 64-bit integers.

// File: rtl/mas4_pkg.sv
package mas4_pkg;
  localparam int NLANE = 4;
  localparam int NLINE = 4;

  typedef enum logic {
    ADDSUB_SUB = 1'b0,
    ADDSUB_ADD = 1'b1
  } addsub_e;
endpackage

// File: rtl/mas4_opt_reg.sv
module mas4_opt_reg
  import mas4_pkg::*;
#(
  parameter int W       = 8,
  parameter bit EN      = 1'b1,
  parameter int CE_SEL  = 0,
  parameter int CLR_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] ce_bank,
  input  logic [NLINE-1:0] clr_bank,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (clr_bank[CLR_SEL]) begin
          q_nxt = '0;
        end else if (ce_bank[CE_SEL]) begin
          q_nxt = d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
        end else begin
          q_r <= q_nxt;
        end
      end

      assign q = q_r;

      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_bank[CE_SEL] && !clr_bank[CLR_SEL]) |=> $stable(q));

      assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bank[CLR_SEL] |=> (q == '0));
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mas4_mult.sv
module mas4_mult #(
  parameter int A_W = 8,
  parameter int B_W = 6
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  input  logic               sgn,
  output logic [A_W+B_W-1:0] p
);
  localparam int PW = A_W + B_W;

  logic [PW-1:0] a_x;
  logic [PW-1:0] b_x;

  // extend both operands to the product width; low PW bits are then exact
  assign a_x = {{B_W{sgn & a[A_W-1]}}, a};
  assign b_x = {{A_W{sgn & b[B_W-1]}}, b};
  assign p   = a_x * b_x;

endmodule

// File: rtl/mas4_combine.sv
module mas4_combine
  import mas4_pkg::*;
#(
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] p0,
  input  logic [PW-1:0] p1,
  input  logic [PW-1:0] p2,
  input  logic [PW-1:0] p3,
  input  logic          add0,
  input  logic          add1,
  input  logic          sgn,
  output logic [PW+1:0] sum
);

  logic [PW:0]   e0, e1, e2, e3;
  logic [PW:0]   r0, r1;
  logic [PW+1:0] x0, x1;

  assign e0 = {sgn & p0[PW-1], p0};
  assign e1 = {sgn & p1[PW-1], p1};
  assign e2 = {sgn & p2[PW-1], p2};
  assign e3 = {sgn & p3[PW-1], p3};

  assign r0 = (add0 == ADDSUB_ADD) ? (e0 + e1) : (e0 - e1);
  assign r1 = (add1 == ADDSUB_ADD) ? (e2 + e3) : (e2 - e3);

  // a difference is signed even in unsigned mode
  assign x0 = {(sgn | (add0 == ADDSUB_SUB)) & r0[PW], r0};
  assign x1 = {(sgn | (add1 == ADDSUB_SUB)) & r1[PW], r1};

  assign sum = x0 + x1;

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sgn && add0 && add1) |-> ((sum >= {1'b0, r0}) && (sum >= {1'b0, r1})));

endmodule

// File: rtl/mas4_slice.sv
module mas4_slice
  import mas4_pkg::*;
#(
  parameter int A_W      = 8,
  parameter int B_W      = 6,
  parameter bit IN_REG   = 1'b1,
  parameter bit PIPE_REG = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  parameter int IN_CE    = 0,
  parameter int IN_CLR   = 1,
  parameter int PIPE_CE  = 1,
  parameter int PIPE_CLR = 2,
  parameter int OUT_CE   = 2,
  parameter int OUT_CLR  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             ce_bank,
  input  logic [3:0]             clr_bank,
  input  logic [4*A_W-1:0]       a_in,
  input  logic [4*B_W-1:0]       b_in,
  input  logic                   add_sel0,
  input  logic                   add_sel1,
  input  logic                   ops_signed,
  input  logic                   shift_a,
  input  logic                   shift_b,
  input  logic [A_W-1:0]         sa_in,
  input  logic [B_W-1:0]         sb_in,
  output logic [A_W-1:0]         sa_out,
  output logic [B_W-1:0]         sb_out,
  output logic [A_W+B_W+1:0]     sum_out
);

  localparam int PW = A_W + B_W;
  localparam int SW = PW + 2;
  localparam int CW = 3;

  logic [A_W-1:0] a_d [NLANE];
  logic [A_W-1:0] a_q [NLANE];
  logic [B_W-1:0] b_d [NLANE];
  logic [B_W-1:0] b_q [NLANE];
  logic [PW-1:0]  prod   [NLANE];
  logic [PW-1:0]  prod_p [NLANE];
  logic [CW-1:0]  ctl_in, ctl_q, ctl_p;
  logic [SW-1:0]  sum_c;

  assign ctl_in = {add_sel0, add_sel1, ops_signed};

  genvar i;
  generate
    for (i = 0; i < NLANE; i++) begin : g_lane
      if (i == 0) begin : g_head
        assign a_d[i] = shift_a ? sa_in : a_in[i*A_W +: A_W];
        assign b_d[i] = shift_b ? sb_in : b_in[i*B_W +: B_W];
      end else begin : g_body
        assign a_d[i] = shift_a ? a_q[i-1] : a_in[i*A_W +: A_W];
        assign b_d[i] = shift_b ? b_q[i-1] : b_in[i*B_W +: B_W];
      end

      mas4_opt_reg #(.W(A_W), .EN(IN_REG), .CE_SEL(IN_CE), .CLR_SEL(IN_CLR)) u_a_reg (
        .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
        .d(a_d[i]), .q(a_q[i]));

      mas4_opt_reg #(.W(B_W), .EN(IN_REG), .CE_SEL(IN_CE), .CLR_SEL(IN_CLR)) u_b_reg (
        .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
        .d(b_d[i]), .q(b_q[i]));

      mas4_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
        .a(a_q[i]), .b(b_q[i]), .sgn(ctl_q[0]), .p(prod[i]));

      mas4_opt_reg #(.W(PW), .EN(PIPE_REG), .CE_SEL(PIPE_CE), .CLR_SEL(PIPE_CLR)) u_p_reg (
        .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
        .d(prod[i]), .q(prod_p[i]));
    end
  endgenerate

  mas4_opt_reg #(.W(CW), .EN(IN_REG), .CE_SEL(IN_CE), .CLR_SEL(IN_CLR)) u_ctl_in (
    .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
    .d(ctl_in), .q(ctl_q));

  mas4_opt_reg #(.W(CW), .EN(PIPE_REG), .CE_SEL(PIPE_CE), .CLR_SEL(PIPE_CLR)) u_ctl_pipe (
    .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
    .d(ctl_q), .q(ctl_p));

  mas4_combine #(.PW(PW)) u_comb (
    .clk(clk), .rst_n(rst_n),
    .p0(prod_p[0]), .p1(prod_p[1]), .p2(prod_p[2]), .p3(prod_p[3]),
    .add0(ctl_p[2]), .add1(ctl_p[1]), .sgn(ctl_p[0]),
    .sum(sum_c));

  mas4_opt_reg #(.W(SW), .EN(OUT_REG), .CE_SEL(OUT_CE), .CLR_SEL(OUT_CLR)) u_out (
    .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
    .d(sum_c), .q(sum_out));

  assign sa_out = a_q[NLANE-1];
  assign sb_out = b_q[NLANE-1];

  generate
    if (IN_REG) begin : g_chain_chk
      assert_chain_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_a && ce_bank[IN_CE] && !clr_bank[IN_CLR]) |=> (sa_out == $past(a_q[NLANE-2])));
      assert_chain_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_b && ce_bank[IN_CE] && !clr_bank[IN_CLR]) |=> (sb_out == $past(b_q[NLANE-2])));
    end
  endgenerate

endmodule

// File: tb/mas4_slice_bench.sv
module mas4_slice_bench;
  localparam int A_W = 8;
  localparam int B_W = 6;
  localparam int SW  = A_W + B_W + 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       d_ce, d_clr;
  logic [A_W-1:0]   d_a [4];
  logic [B_W-1:0]   d_b [4];
  logic             d_add0, d_add1, d_sgn, d_sha, d_shb;
  logic [A_W-1:0]   d_sa;
  logic [B_W-1:0]   d_sb;
  logic [A_W-1:0]   sa_out;
  logic [B_W-1:0]   sb_out;
  logic [SW-1:0]    sum_out;

  always #4 clk = ~clk;

  mas4_slice u_mas4_slice (
    .clk(clk), .rst_n(rst_n), .ce_bank(d_ce), .clr_bank(d_clr),
    .a_in({d_a[3], d_a[2], d_a[1], d_a[0]}),
    .b_in({d_b[3], d_b[2], d_b[1], d_b[0]}),
    .add_sel0(d_add0), .add_sel1(d_add1), .ops_signed(d_sgn),
    .shift_a(d_sha), .shift_b(d_shb), .sa_in(d_sa), .sb_in(d_sb),
    .sa_out(sa_out), .sb_out(sb_out), .sum_out(sum_out));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";
  logic [SW-1:0]  exp_hist [0:2047];
  logic [A_W-1:0] m_a [4];
  logic [B_W-1:0] m_b [4];
  logic           m_add0, m_add1, m_sgn;

  function automatic longint sval(longint raw, int w, logic s);
    if (s && raw[w-1]) return raw - (longint'(1) << w);
    return raw;
  endfunction

  function automatic logic [SW-1:0] model_sum();
    longint p [4];
    longint r0, r1, t;
    for (int i = 0; i < 4; i++)
      p[i] = sval(longint'(m_a[i]), A_W, m_sgn) * sval(longint'(m_b[i]), B_W, m_sgn);
    r0 = m_add0 ? p[0] + p[1] : p[0] - p[1];
    r1 = m_add1 ? p[2] + p[3] : p[2] - p[3];
    t  = r0 + r1;
    return t[SW-1:0];
  endfunction

  task automatic check(string req, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // sample at the falling edge, then leave drives to be set for the next rising edge
  task automatic sample();
    @(negedge clk);
    if (cyc >= 3) check(cur_req, longint'(sum_out), longint'(exp_hist[cyc-3]));
    check("R9 chain A", longint'(sa_out), longint'(m_a[3]));
    check("R9 chain B", longint'(sb_out), longint'(m_b[3]));
  endtask

  // update the input-stage model as the next rising edge will
  task automatic commit();
    if (d_clr[1]) begin
      for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_b[i] = '0; end
      m_add0 = 1'b0; m_add1 = 1'b0; m_sgn = 1'b0;
    end else if (d_ce[0]) begin
      for (int i = 3; i >= 0; i--) begin
        if (d_sha) m_a[i] = (i == 0) ? d_sa : m_a[i-1];
        else       m_a[i] = d_a[i];
        if (d_shb) m_b[i] = (i == 0) ? d_sb : m_b[i-1];
        else       m_b[i] = d_b[i];
      end
      m_add0 = d_add0; m_add1 = d_add1; m_sgn = d_sgn;
    end
    exp_hist[cyc] = model_sum();
    cyc++;
  endtask

  task automatic rand_drive(bit allow_shift);
    int pat;
    pat = $urandom % 8;
    for (int i = 0; i < 4; i++) begin
      case (pat)
        0: begin d_a[i] = '1; d_b[i] = '1; end
        1: begin d_a[i] = {1'b1, {(A_W-1){1'b0}}}; d_b[i] = {1'b1, {(B_W-1){1'b0}}}; end
        2: begin d_a[i] = '0; d_b[i] = '1; end
        default: begin d_a[i] = A_W'($urandom); d_b[i] = B_W'($urandom); end
      endcase
    end
    d_add0 = 1'($urandom); d_add1 = 1'($urandom); d_sgn = 1'($urandom);
    d_sha = allow_shift & (($urandom % 4) == 0);
    d_shb = allow_shift & (($urandom % 4) == 0);
    d_sa = A_W'($urandom); d_sb = B_W'($urandom);
    d_ce  = {1'($urandom), 3'b111};          // line 3 unused (R8)
    d_clr = {3'b000, 1'($urandom)};          // line 0 unused (R8)
  endtask

  task automatic plain_cycle();
    sample();
    rand_drive(1'b0);
    commit();
  endtask

  task automatic set_ops(logic [A_W-1:0] av, logic [B_W-1:0] bv,
                         logic a0, logic a1, logic s);
    for (int i = 0; i < 4; i++) begin d_a[i] = av; d_b[i] = bv; end
    d_add0 = a0; d_add1 = a1; d_sgn = s;
    d_sha = 1'b0; d_shb = 1'b0; d_ce = 4'hF; d_clr = 4'h0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    rst_n = 1'b0;
    rand_drive(1'b1);
    for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_b[i] = '0; end
    m_add0 = 1'b0; m_add1 = 1'b0; m_sgn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sum", longint'(sum_out), 0);
    check("R1 sa", longint'(sa_out), 0);
    check("R1 sb", longint'(sb_out), 0);
    for (int i = 0; i < 4; i++) begin d_a[i] = '0; d_b[i] = '0; end
    d_ce = 4'hF; d_clr = 4'h0; d_sha = 1'b0; d_shb = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) exp_hist[i] = '0;

    // random phase: mixed modes, shift chains, unused lines toggling
    cur_req = "R2 R3 R5 R8";
    for (int n = 0; n < 600; n++) begin
      sample();
      rand_drive(1'b1);
      commit();
    end

    // directed corners
    cur_req = "R4 unsigned max add";
    sample(); set_ops('1, '1, 1'b1, 1'b1, 1'b0); commit();
    sample(); set_ops('0, '1, 1'b0, 1'b0, 1'b0);
    d_a[0] = '0; d_a[1] = '1; d_a[2] = '0; d_a[3] = '1; commit();
    cur_req = "R3 signed min";
    sample(); set_ops({1'b1, {(A_W-1){1'b0}}}, {1'b1, {(B_W-1){1'b0}}}, 1'b1, 1'b1, 1'b1); commit();
    sample(); set_ops({1'b1, {(A_W-1){1'b0}}}, '1, 1'b0, 1'b1, 1'b1); commit();
    repeat (4) plain_cycle();

    // R6: input stage hold
    cur_req = "R6 input hold";
    sample(); rand_drive(1'b0); d_ce[0] = 1'b0; commit();
    sample(); rand_drive(1'b0); d_ce[0] = 1'b0; commit();
    repeat (4) plain_cycle();
    // R6: pipeline stage hold
    cur_req = "R6 pipe hold";
    sample(); rand_drive(1'b0); d_ce[1] = 1'b0; commit();
    exp_hist[cyc-2] = exp_hist[cyc-3];
    repeat (4) plain_cycle();
    // R6: output stage hold
    cur_req = "R6 out hold";
    sample(); rand_drive(1'b0); d_ce[2] = 1'b0; commit();
    exp_hist[cyc-3] = exp_hist[cyc-4];
    repeat (4) plain_cycle();

    // R7: per-stage clears, others unaffected
    cur_req = "R7 input clear";
    sample(); rand_drive(1'b0); d_clr[1] = 1'b1; d_ce[0] = 1'b0; commit();
    repeat (4) plain_cycle();
    cur_req = "R7 pipe clear";
    sample(); rand_drive(1'b0); d_clr[2] = 1'b1; commit();
    exp_hist[cyc-2] = '0;
    repeat (4) plain_cycle();
    cur_req = "R7 out clear";
    sample(); rand_drive(1'b0); d_clr[3] = 1'b1; d_ce[2] = 1'b0; commit();
    exp_hist[cyc-3] = '0;
    repeat (4) plain_cycle();

    // R9: continuous shifting of both chains
    cur_req = "R9 shift";
    for (int n = 0; n < 12; n++) begin
      sample(); rand_drive(1'b0); d_sha = 1'b1; d_shb = 1'b1; commit();
    end
    cur_req = "R5 drain";
    repeat (4) plain_cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule